// File: doc/BRIEF.md
# Matrix-Coded Fault-Tolerant FIR Bank

This block runs four identical 8-tap FIR filters on four independent sample streams. It protects them with only two extra filters. Before filtering, the four input samples are mixed by a fixed 6x4 integer coding matrix:

- Rows 1 to 4 pass each lane through unchanged.
- Row 5 forms the plain sum of the four lanes.
- Row 6 forms a weighted sum with weights 1, 2, 3 and 4.

Because filtering is linear, the two redundant filter outputs must equal the same combinations of the four lane outputs. Four integer consistency checks are built on that fact. Each check compares two four-filter recovery sets that share five filters and leaves one filter out.

The pattern of failing checks points to one faulty filter. Where the pattern alone is ambiguous, the ratio between two check values settles it: filters 2 and 3 upset all four checks but with different integer multiples. The four outputs are then taken from a recovery set that does not use the faulty filter. A lane whose own filter failed is rebuilt as the sum filter minus the other three lanes.

An upset-emulation input adds a chosen value to the output register of one chosen filter. This lets a single error be placed on any filter while the bank runs.

Top module: `coded_fir_bank`

## Requirements
- R1: After a synchronous active-low reset, all four outputs are 0, `fault_flag` is 0 and `fault_idx` is 0.
- R2: With no injected error, output lane k equals the 8-tap FIR of input lane k, `sum over j of COEFS[j]*in_k(t-3-j)`. Here in_k(n) is the value sampled at clock edge n, taps are stored in `COEFS` with tap 0 in the least significant CW bits, and samples from before reset count as 0.
- R3: Filter 5 filters the sum of the four lanes and filter 6 filters the weighted sum `in0+2*in1+3*in2+4*in3`. With no injected error, `fault_flag` stays 0 for any inputs, including full-scale values of both signs.
- R4: When `inj_sel` is k in 1..6 and `inj_val` is non-zero at clock edge n, then after edge n+1 `fault_flag` is 1 and `fault_idx` is k. Filters 1..4 carry lanes 0..3, filter 5 is the sum filter and filter 6 is the weighted filter.
- R5: During a single injected error on any filter, all four outputs still equal the error-free FIR results of R2. A lane whose filter is faulty is rebuilt as filter 5 minus the other three lanes. An error on filter 5 or 6 leaves the lane filters in use.
- R6: Errors on filters 2 and 3, which make all four checks fail, are told apart. The check that excludes filter 1 equals the check that excludes filter 6 for a filter-2 error, and is twice it for a filter-3 error.
- R7: `fault_flag` is 1 exactly when `fault_idx` is non-zero. `fault_idx` is 7 when the failing-check pattern matches no single filter.
- R8: `inj_sel` = 0 injects nothing. A non-zero `inj_sel` with `inj_val` = 0 also has no effect on outputs, flag or index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in0 | input | DW | Signed sample, lane 0 |
| in1 | input | DW | Signed sample, lane 1 |
| in2 | input | DW | Signed sample, lane 2 |
| in3 | input | DW | Signed sample, lane 3 |
| inj_sel | input | 3 | Filter receiving the emulated upset (1..6), 0 for none |
| inj_val | input | IW | Signed value added to the selected filter output register |
| out0 | output | FW | Corrected filtered lane 0 |
| out1 | output | FW | Corrected filtered lane 1 |
| out2 | output | FW | Corrected filtered lane 2 |
| out3 | output | FW | Corrected filtered lane 3 |
| fault_flag | output | 1 | A check failed this cycle |
| fault_idx | output | 3 | Faulty filter 1..6, 0 none, 7 unresolved |

## Verification
The bench puts one error on each of the six filters in turn, using error values of both signs and including 1 and -1. A decoder that relied only on the failing-check pattern would report the same index for filters 2 and 3, and one that mixed up the excluded filter would rebuild the wrong lane, which shows as an output differing from the reference FIR. Full-scale inputs of both signs, and alternation between them, expose an undersized mixing or accumulation width as false alarms or wrong outputs. A zero-valued injection on an active selector catches a decoder that reacts to the selector rather than to the data. An off-by-one in the three-cycle data latency, or in the two-cycle flag latency, shows up on the first impulse and on the first and last cycle of each injection window.

// File: rtl/cfb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the coded FIR bank.
// Assumes four data lanes and two redundant filters, fixed by the coding matrix.
package cfb_pkg;
    localparam int NLANE = 4;
    localparam int NFILT = 6;
    typedef logic [2:0] fidx_t;
    localparam fidx_t IDX_NONE  = 3'd0;
    localparam fidx_t IDX_MULTI = 3'd7;
endpackage

// File: rtl/cfb_mixer.sv
`timescale 1ns/1ps
// Module: cfb_mixer
// Encodes four signed lane samples into six filter inputs using the fixed matrix
// [I4; 1 1 1 1; 1 2 3 4]. Assumes UW >= DW+4 so that no encoded value overflows.
module cfb_mixer
    import cfb_pkg::*;
#(
    parameter int DW = 12,
    parameter int UW = 16
) (
    input  logic signed [DW-1:0] x [NLANE],
    output logic signed [UW-1:0] u [NFILT]
);
    logic signed [UW-1:0] xe [NLANE];

    // Sign-extend the lane samples to the encoded width.
    always_comb begin
        for (int i = 0; i < NLANE; i++) begin
            xe[i] = UW'(x[i]);
        end
    end

    // Identity rows, plain-sum row and weighted-sum row.
    always_comb begin
        for (int i = 0; i < NLANE; i++) begin
            u[i] = xe[i];
        end
        u[4] = xe[0] + xe[1] + xe[2] + xe[3];
        u[5] = xe[0] + (xe[1] + xe[1]) + (xe[2] + xe[2] + xe[2])
             + ((xe[3] + xe[3]) + (xe[3] + xe[3]));
    end
endmodule

// File: rtl/cfb_fir.sv
`timescale 1ns/1ps
// Module: cfb_fir
// One direct-form FIR with NTAPS signed taps and a registered output.
// An additive upset term is folded into the output register for fault emulation.
// Assumes FW covers UW+CW+log2(NTAPS) bits, so the accumulation never wraps.
module cfb_fir #(
    parameter int UW    = 16,
    parameter int CW    = 12,
    parameter int NTAPS = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter int FW    = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [UW-1:0] u,
    input  logic signed [FW-1:0] upset,
    output logic signed [FW-1:0] f_q
);
    logic signed [UW-1:0] tap_q [NTAPS];
    logic signed [FW-1:0] acc;

    // Sum of products over the delay line.
    always_comb begin
        acc = '0;
        for (int j = 0; j < NTAPS; j++) begin
            acc = acc + FW'(tap_q[j]) * FW'($signed(COEFS[j*CW +: CW]));
        end
    end

    // Shift the delay line and register the filter output plus any upset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAPS; j++) tap_q[j] <= '0;
            f_q <= '0;
        end else begin
            tap_q[0] <= u;
            for (int j = 1; j < NTAPS; j++) tap_q[j] <= tap_q[j-1];
            f_q <= acc + upset;
        end
    end
endmodule

// File: rtl/cfb_decider.sv
`timescale 1ns/1ps
// Module: cfb_decider
// Forms the four consistency checks of the coded bank, each leaving out one of
// filters 1, 4, 5 and 6. It locates a single faulty filter and registers the
// verdict together with an aligned copy of the six filter outputs.
// Assumes at most one faulty filter and SW >= FW+5.
module cfb_decider
    import cfb_pkg::*;
#(
    parameter int FW = 31,
    parameter int SW = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] f_q [NFILT],
    output logic signed [FW-1:0] f_d [NFILT],
    output logic                 err_q,
    output fidx_t                idx_q
);
    localparam logic signed [SW-1:0] K2 = SW'(2);
    localparam logic signed [SW-1:0] K3 = SW'(3);
    localparam logic signed [SW-1:0] K4 = SW'(4);

    logic signed [SW-1:0] fe [NFILT];
    logic signed [SW-1:0] s_x1, s_x4, s_x5, s_x6;
    logic [3:0] zero_v;
    fidx_t idx_c;

    // Sign-extend the filter outputs to the check width.
    always_comb begin
        for (int i = 0; i < NFILT; i++) fe[i] = SW'(f_q[i]);
    end

    // Check residuals, each zero when the two recovery sets sharing its five filters agree.
    always_comb begin
        s_x1 = fe[4] - fe[5] + fe[1] + K2*fe[2] + K3*fe[3];
        s_x4 = K4*fe[4] - K3*fe[0] - K2*fe[1] - fe[2] - fe[5];
        s_x5 = fe[0] + K2*fe[1] + K3*fe[2] + K4*fe[3] - fe[5];
        s_x6 = fe[0] + fe[1] + fe[2] + fe[3] - fe[4];
        zero_v = {s_x1 == '0, s_x4 == '0, s_x5 == '0, s_x6 == '0};
    end

    // Map the check pattern, and the ratio of two checks when all four fail, to a filter.
    always_comb begin
        case (zero_v)
            4'b1111: idx_c = IDX_NONE;
            4'b1000: idx_c = 3'd1;
            4'b0100: idx_c = 3'd4;
            4'b0010: idx_c = 3'd5;
            4'b0001: idx_c = 3'd6;
            4'b0000: begin
                if (s_x1 == s_x6)         idx_c = 3'd2;
                else if (s_x1 == K2*s_x6) idx_c = 3'd3;
                else                      idx_c = IDX_MULTI;
            end
            default: idx_c = IDX_MULTI;
        endcase
    end

    // Register the verdict and the filter outputs it refers to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFILT; i++) f_d[i] <= '0;
            err_q <= 1'b0;
            idx_q <= IDX_NONE;
        end else begin
            for (int i = 0; i < NFILT; i++) f_d[i] <= f_q[i];
            err_q <= (zero_v != 4'b1111);
            idx_q <= idx_c;
        end
    end

    // R7: flag and index agree.
    p_flag_has_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (idx_q != IDX_NONE));
    p_idx_has_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q |-> (idx_q == IDX_NONE));
endmodule

// File: rtl/cfb_corrector.sv
`timescale 1ns/1ps
// Module: cfb_corrector
// Selects the final lane outputs. A lane whose own filter is flagged is rebuilt
// from the sum filter minus the other three lanes. Otherwise the lane filter is used.
// Assumes the verdict and the filter outputs are aligned (same register stage).
module cfb_corrector
    import cfb_pkg::*;
#(
    parameter int FW = 31
) (
    input  logic signed [FW-1:0] f_d [NFILT],
    input  fidx_t                idx,
    output logic signed [FW-1:0] y [NLANE]
);
    logic signed [FW-1:0] lane_tot;

    // Total of the four lane filters.
    always_comb lane_tot = f_d[0] + f_d[1] + f_d[2] + f_d[3];

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic signed [FW-1:0] rebuilt;
        // Recover this lane from the set that leaves its own filter out.
        always_comb begin
            rebuilt = f_d[4] - (lane_tot - f_d[i]);
            y[i]    = (idx == fidx_t'(i + 1)) ? rebuilt : f_d[i];
        end
    end
endmodule

// File: rtl/coded_fir_bank.sv
`timescale 1ns/1ps
// Module: coded_fir_bank
// Four identical FIR lanes guarded by two redundant filters through integer
// matrix coding. It locates and corrects a single faulty filter. Data latency is
// three clocks and verdict latency two clocks after an upset is applied.
// Assumes at most one faulty filter at a time and no overflow of the FW datapath.
module coded_fir_bank
    import cfb_pkg::*;
#(
    parameter int DW    = 12,
    parameter int CW    = 12,
    parameter int NTAPS = 8,
    parameter int IW    = 16,
    parameter logic [NTAPS*CW-1:0] COEFS = {12'sd3, -12'sd5, 12'sd12, 12'sd40,
                                            12'sd40, 12'sd12, -12'sd5, 12'sd3},
    localparam int UW = DW + 4,
    localparam int FW = UW + CW + $clog2(NTAPS),
    localparam int SW = FW + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] in0,
    input  logic signed [DW-1:0] in1,
    input  logic signed [DW-1:0] in2,
    input  logic signed [DW-1:0] in3,
    input  logic [2:0]           inj_sel,
    input  logic signed [IW-1:0] inj_val,
    output logic signed [FW-1:0] out0,
    output logic signed [FW-1:0] out1,
    output logic signed [FW-1:0] out2,
    output logic signed [FW-1:0] out3,
    output logic                 fault_flag,
    output logic [2:0]           fault_idx
);
    logic signed [DW-1:0] x_v [NLANE];
    logic signed [UW-1:0] u_v [NFILT];
    logic signed [FW-1:0] f_q [NFILT];
    logic signed [FW-1:0] f_d [NFILT];
    logic signed [FW-1:0] y_v [NLANE];
    fidx_t                idx_w;
    logic                 err_w;

    // Gather the lane inputs.
    always_comb begin
        x_v[0] = in0; x_v[1] = in1; x_v[2] = in2; x_v[3] = in3;
    end

    cfb_mixer #(.DW(DW), .UW(UW)) u_mix (.x(x_v), .u(u_v));

    for (genvar k = 0; k < NFILT; k++) begin : g_filt
        logic signed [FW-1:0] upset;
        // Route the emulated upset to the selected filter only.
        always_comb upset = (inj_sel == 3'(k + 1)) ? FW'(inj_val) : '0;
        cfb_fir #(.UW(UW), .CW(CW), .NTAPS(NTAPS), .COEFS(COEFS), .FW(FW)) u_fir (
            .clk(clk), .rst_n(rst_n), .u(u_v[k]), .upset(upset), .f_q(f_q[k])
        );
    end

    cfb_decider #(.FW(FW), .SW(SW)) u_dec (
        .clk(clk), .rst_n(rst_n), .f_q(f_q), .f_d(f_d), .err_q(err_w), .idx_q(idx_w)
    );

    cfb_corrector #(.FW(FW)) u_cor (.f_d(f_d), .idx(idx_w), .y(y_v));

    // Drive the output ports.
    always_comb begin
        out0 = y_v[0]; out1 = y_v[1]; out2 = y_v[2]; out3 = y_v[3];
        fault_flag = err_w;
        fault_idx  = idx_w;
    end

    // R4: a non-zero upset on filter k is located two edges later.
    p_locate_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel != 3'd0 && inj_sel != 3'd7 && inj_val != '0)
        |=> ##1 (fault_flag && fault_idx == $past(inj_sel, 2)));
    // R3: without an upset the checks stay consistent.
    p_clean_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel == 3'd0) |=> ##1 !fault_flag);
    // R8: a zero-valued upset on an active selector changes nothing.
    p_zero_upset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel != 3'd0 && inj_val == '0) |=> ##1 (fault_idx == IDX_NONE));
endmodule

// File: tb/coded_fir_bank_tb.sv
`timescale 1ns/1ps
module coded_fir_bank_tb;
    localparam int NCYC  = 320;
    localparam int NTAPS = 8;
    localparam int FW    = 31;
    localparam longint CO [NTAPS] = '{3, -5, 12, 40, 40, 12, -5, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [11:0] in0 = '0, in1 = '0, in2 = '0, in3 = '0;
    logic [2:0] inj_sel = '0;
    logic signed [15:0] inj_val = '0;
    logic signed [FW-1:0] out0, out1, out2, out3;
    logic fault_flag;
    logic [2:0] fault_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    longint xh [4][NCYC];
    int     sel_h [NCYC];
    longint val_h [NCYC];

    always #5 clk = ~clk;

    coded_fir_bank u_dut (
        .clk(clk), .rst_n(rst_n), .in0(in0), .in1(in1), .in2(in2), .in3(in3),
        .inj_sel(inj_sel), .inj_val(inj_val), .out0(out0), .out1(out1),
        .out2(out2), .out3(out3), .fault_flag(fault_flag), .fault_idx(fault_idx)
    );

    function automatic int stim(int lane, int c);
        if (c < 8) return 0;
        if (c < 24) return (c == 8 + 4*lane) ? 1 : 0;
        if (c < 40) return (c - 24)*100 - 800 + lane;
        if (c < 60) return 2047;
        if (c < 80) return -2048;
        if (c < 100) return ((c + lane) % 2 == 1) ? 2047 : -2048;
        return ((c*1103 + lane*12345 + c*c*7) % 4096) - 2048;
    endfunction

    function automatic int inj_s(int c);
        int seg, pos;
        if (c < 110 || c >= 110 + 7*12) return 0;
        seg = (c - 110) / 12; pos = (c - 110) % 12;
        if (pos >= 8) return 0;
        return (seg < 6) ? seg + 1 : 3;
    endfunction

    function automatic longint inj_v(int c);
        longint tbl [7] = '{5, -7, 300, -1, 999, 1, 0};
        if (c < 110 || c >= 110 + 7*12) return 0;
        return tbl[(c - 110) / 12];
    endfunction

    function automatic longint ref_y(int lane, int m);
        longint acc = 0;
        for (int j = 0; j < NTAPS; j++) begin
            int n = m - 3 - j;
            if (n >= 0) acc += CO[j] * xh[lane][n];
        end
        return acc;
    endfunction

    task automatic check(string tag, string what, int c, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s cyc=%0d act=%0d exp=%0d", tag, what, c, act, exp);
        end
    endtask

    task automatic check_cycle(int m);
        int es = 0; longint ev = 0; int e_idx; string t_idx, t_out;
        longint act_y [4];
        if (m >= 2) begin es = sel_h[m-2]; ev = val_h[m-2]; end
        e_idx = (es >= 1 && es <= 6 && ev != 0) ? es : 0;
        if (m < 3)                      t_idx = "R1";
        else if (e_idx == 2 || e_idx == 3) t_idx = "R6";
        else if (e_idx != 0)            t_idx = "R4";
        else if (es != 0)               t_idx = "R8";
        else                            t_idx = "R3";
        t_out = (m < 3) ? "R1" : (e_idx != 0) ? "R5" : (es != 0) ? "R8" : "R2";
        check(t_idx, "fault_idx", m, longint'(fault_idx), longint'(e_idx));
        check(t_idx, "fault_flag", m, longint'(fault_flag), longint'(e_idx != 0));
        check("R7", "flag_vs_idx", m, longint'(fault_flag), longint'(fault_idx != 3'd0));
        act_y[0] = out0; act_y[1] = out1; act_y[2] = out2; act_y[3] = out3;
        for (int l = 0; l < 4; l++) begin
            check(t_out, $sformatf("out%0d", l), m, act_y[l], ref_y(l, m));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            check_cycle(c);
            for (int l = 0; l < 4; l++) xh[l][c] = stim(l, c);
            sel_h[c] = inj_s(c);
            val_h[c] = inj_v(c);
            in0 = 12'(xh[0][c]); in1 = 12'(xh[1][c]);
            in2 = 12'(xh[2][c]); in3 = 12'(xh[3][c]);
            inj_sel = 3'(sel_h[c]);
            inj_val = 16'(val_h[c]);
            @(negedge clk);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule